// File: doc/BRIEF.md
# Mixed-Width Tagged Frame Buffer

This block is a dual-port store for a page-organised monochrome graphic LCD. It holds one full frame and, above it, room for controller command entries. Every stored byte has a ninth tag bit. By convention a tag of 0 marks display data and a tag of 1 marks a command for the LCD controller. The memory passes the tag through without acting on it.

A host writes 36-bit words: four byte lanes, each with its own tag. A display-side scanner reads single 9-bit entries (one byte plus its tag), one address after another. Each port has its own clock and reset, and the two clocks may be the same net. The frame is 8 pages of 132 bytes, and each byte covers 8 vertical pixels. Page p, column c sits at narrow address 132·p + c, so one page takes 33 host word writes.

Both request interfaces use valid/ready. Neither port ever applies back-pressure. Each ready is low while its port is in reset and high from the first clock edge after reset is released. The read response has no ready of its own, so the consumer must take `rsp_valid` in the cycle it appears.

Top module: `fb_tagged_buffer`

## Requirements
- R1: All 2048 narrow entries can be written and read back independently, across the full address range.
- R2: On a host write to word address A, lane k (`wr_data[8k+7:8k]` with `wr_tag[k]`) is stored at narrow address 4·A+k.
- R3: The tag bit is returned unchanged on `rsp_tag` together with its byte (0 = display data, 1 = command).
- R4: A read request accepted on a `rd_clk` edge raises `rsp_valid`, with the addressed entry on `rsp_data`/`rsp_tag`, for exactly the following cycle.
- R5: In a cycle with no accepted read, `rsp_valid` is low and `rsp_data`/`rsp_tag` keep their previous values.
- R6: When a read and a write hit the same location on the same edge of a shared clock, the read returns the old contents. The next read returns the new contents.
- R7: A write takes effect only when `wr_valid` and `wr_ready` are both high. Address and data presented with `wr_valid` low change nothing.
- R8: `wr_ready` and `rd_ready` are low during their port's reset and high from the first edge after release. They stay high after that.
- R9: The 33 consecutive word writes from word 33·p fill exactly narrow addresses 132·p to 132·p+131, and the neighbouring pages are not touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Host port clock |
| wr_rst_n | input | 1 | Host port asynchronous reset, active low |
| wr_valid | input | 1 | Host write request valid |
| wr_ready | output | 1 | Host port accepts writes |
| wr_addr | input | 9 | Host word address |
| wr_data | input | 32 | Four data bytes, lane 0 in bits [7:0] |
| wr_tag | input | 4 | Tag per lane, bit k for lane k |
| rd_clk | input | 1 | Display port clock |
| rd_rst_n | input | 1 | Display port asynchronous reset, active low |
| rd_valid | input | 1 | Display read request valid |
| rd_ready | output | 1 | Display port accepts reads |
| rd_addr | input | 11 | Narrow entry address |
| rsp_valid | output | 1 | Read response valid, one cycle after acceptance |
| rsp_data | output | 8 | Returned byte |
| rsp_tag | output | 1 | Returned tag bit |

## Verification
The bench builds the block with its default parameters: 2048 narrow entries in four lanes of 512 words. This makes an exhaustive sweep practical. Every word is written with an arithmetic pattern and every narrow entry is read back, twice, with different patterns. That covers the whole frame region and the command area above it. Both ports are driven from one shared clock, which makes a same-edge read/write collision reachable. A single page is rewritten with 33 words to check its boundaries against the neighbouring pages.

// File: rtl/fb_pkg.sv
package fb_pkg;
  localparam int FB_BYTE_W = 8;

  typedef struct packed {
    logic                 tag;
    logic [FB_BYTE_W-1:0] data;
  } fb_entry_t;

  localparam int FB_ENTRY_W = $bits(fb_entry_t);
endpackage

// File: rtl/fb_port_gate.sv
module fb_port_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  output logic ready,
  output logic fire
);
  logic ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign ready = ready_q;
  assign fire  = valid && ready_q;
endmodule

// File: rtl/fb_lane_bank.sv
module fb_lane_bank
  import fb_pkg::*;
#(
  parameter int ROWS  = 512,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic             wr_clk,
  input  logic             we,
  input  logic [ROW_W-1:0] waddr,
  input  fb_entry_t        wentry,
  input  logic             rd_clk,
  input  logic             rd_rst_n,
  input  logic             re,
  input  logic [ROW_W-1:0] raddr,
  output fb_entry_t        rentry
);
  fb_entry_t mem [ROWS];
  fb_entry_t rq;

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wentry;
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) rq <= '0;
    else if (re)   rq <= mem[raddr];
  end

  assign rentry = rq;
endmodule

// File: rtl/fb_tagged_buffer.sv
module fb_tagged_buffer
  import fb_pkg::*;
#(
  parameter int NARROW_DEPTH = 2048,
  parameter int LANES        = 4,
  parameter int AW_N         = $clog2(NARROW_DEPTH),
  parameter int AW_W         = $clog2(NARROW_DEPTH / LANES)
) (
  input  logic                       wr_clk,
  input  logic                       wr_rst_n,
  input  logic                       wr_valid,
  output logic                       wr_ready,
  input  logic [AW_W-1:0]            wr_addr,
  input  logic [LANES*FB_BYTE_W-1:0] wr_data,
  input  logic [LANES-1:0]           wr_tag,
  input  logic                       rd_clk,
  input  logic                       rd_rst_n,
  input  logic                       rd_valid,
  output logic                       rd_ready,
  input  logic [AW_N-1:0]            rd_addr,
  output logic                       rsp_valid,
  output logic [FB_BYTE_W-1:0]       rsp_data,
  output logic                       rsp_tag
);
  localparam int ROWS  = NARROW_DEPTH / LANES;
  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic wr_fire, rd_fire;

  fb_port_gate u_wgate (
    .clk(wr_clk), .rst_n(wr_rst_n), .valid(wr_valid),
    .ready(wr_ready), .fire(wr_fire)
  );

  fb_port_gate u_rgate (
    .clk(rd_clk), .rst_n(rd_rst_n), .valid(rd_valid),
    .ready(rd_ready), .fire(rd_fire)
  );

  // Narrow address splits into row (word address) and lane select.
  logic [AW_W-1:0]  rd_row;
  logic [SEL_W-1:0] rd_lane;
  assign rd_row  = rd_addr[AW_N-1 -: AW_W];
  assign rd_lane = SEL_W'(rd_addr[AW_N-AW_W-1:0]);

  fb_entry_t lane_out [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    fb_entry_t wentry;
    assign wentry.tag  = wr_tag[k];
    assign wentry.data = wr_data[k*FB_BYTE_W +: FB_BYTE_W];

    fb_lane_bank #(.ROWS(ROWS), .ROW_W(AW_W)) u_bank (
      .wr_clk  (wr_clk),
      .we      (wr_fire),
      .waddr   (wr_addr),
      .wentry  (wentry),
      .rd_clk  (rd_clk),
      .rd_rst_n(rd_rst_n),
      .re      (rd_fire),
      .raddr   (rd_row),
      .rentry  (lane_out[k])
    );
  end

  logic [SEL_W-1:0] sel_q;
  logic             vld_q;

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      sel_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= rd_fire;
      if (rd_fire) sel_q <= rd_lane;
    end
  end

  fb_entry_t picked;
  assign picked    = lane_out[sel_q];
  assign rsp_valid = vld_q;
  assign rsp_data  = picked.data;
  assign rsp_tag   = picked.tag;
endmodule

// File: rtl/fb_checker.sv
module fb_checker (
  input logic       wr_clk,
  input logic       wr_rst_n,
  input logic       wr_ready,
  input logic       rd_clk,
  input logic       rd_rst_n,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic       rsp_valid,
  input logic [7:0] rsp_data,
  input logic       rsp_tag
);
  AST_RSP_AFTER_REQ: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_valid && rd_ready) |=> rsp_valid); // R4
  AST_RSP_ONLY_ON_REQ: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !(rd_valid && rd_ready) |=> !rsp_valid); // R5
  AST_RSP_HOLD: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !(rd_valid && rd_ready) |=> $stable({rsp_tag, rsp_data})); // R5
  AST_WR_READY_UP: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    1'b1 |=> wr_ready); // R8
  AST_RD_READY_UP: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    1'b1 |=> rd_ready); // R8
endmodule

bind fb_tagged_buffer fb_checker u_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_ready(wr_ready),
  .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .rsp_tag(rsp_tag)
);

// File: tb/sim_fb_tagged_buffer.sv
module sim_fb_tagged_buffer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [8:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_tag = '0;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [10:0] rd_addr = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        rsp_tag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fb_tagged_buffer u0 (
    .wr_clk(clk), .wr_rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_tag(wr_tag),
    .rd_clk(clk), .rd_rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_tag(rsp_tag)
  );

  function automatic logic [8:0] pat(int n, int pass);
    int d;
    d = (n * 37 + pass * 101 + (n >> 5)) & 255;
    return {1'(((n >> 1) ^ n ^ pass) & 1), 8'(d)};
  endfunction

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_word(int a, int pass);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = 9'(a);
    for (int k = 0; k < 4; k++) begin
      logic [8:0] e;
      e = pat(4 * a + k, pass);
      wr_data[8*k +: 8] = e[7:0];
      wr_tag[k]         = e[8];
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic read_entry(int n, output logic [8:0] got, output logic v);
    @(negedge clk);
    rd_valid = 1'b1;
    rd_addr  = 11'(n);
    @(negedge clk);
    rd_valid = 1'b0;
    got = {rsp_tag, rsp_data};
    v   = rsp_valid;
  endtask

  initial begin
    logic [8:0] got, last;
    logic v;
    int bad;
    repeat (3) @(negedge clk);
    // R8: readies low and no response during reset
    check("R8 reset", {6'd0, wr_ready, rd_ready, rsp_valid}, 9'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 ready", {7'd0, wr_ready, rd_ready}, 9'd3);

    // R1 R2 R3: full sweep, two passes
    for (int pass = 0; pass < 2; pass++) begin
      for (int a = 0; a < 512; a++) write_word(a, pass);
      bad = 0;
      for (int n = 0; n < 2048; n++) begin
        read_entry(n, got, v);
        if (!v) bad++;
        if (got !== pat(n, pass)) begin
          bad++;
          if (bad < 4) check("R1 R2 R3 sweep entry", got, pat(n, pass));
        end
      end
      check("R1 R2 R3 sweep mismatches", 9'(bad), 9'd0);
    end

    // R4: valid one cycle after request, then low
    read_entry(1055, got, v);
    check("R4 rsp_valid", {8'd0, v}, 9'd1);
    check("R4 data", got, pat(1055, 1));
    last = got;
    // R5: idle cycles keep data and drop valid
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R5 valid low", {8'd0, rsp_valid}, 9'd0);
      check("R5 hold", {rsp_tag, rsp_data}, last);
    end

    // R9: rewrite page 3 with 33 words
    for (int a = 99; a < 132; a++) write_word(a, 2);
    read_entry(395, got, v); check("R9 below page", got, pat(395, 1));
    read_entry(396, got, v); check("R9 page first", got, pat(396, 2));
    read_entry(527, got, v); check("R9 page last", got, pat(527, 2));
    read_entry(528, got, v); check("R9 above page", got, pat(528, 1));

    // R6: same-edge read and write of narrow 21 (word 5 lane 1)
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 9'd5;
    for (int k = 0; k < 4; k++) begin
      logic [8:0] e;
      e = pat(20 + k, 3);
      wr_data[8*k +: 8] = e[7:0];
      wr_tag[k] = e[8];
    end
    rd_valid = 1'b1; rd_addr = 11'd21;
    @(negedge clk);
    wr_valid = 1'b0; rd_valid = 1'b0;
    check("R6 old contents", {rsp_tag, rsp_data}, pat(21, 1));
    read_entry(21, got, v); check("R6 new contents", got, pat(21, 3));

    // R7: write presented with valid low is ignored
    @(negedge clk);
    wr_valid = 1'b0; wr_addr = 9'd6; wr_data = 32'hA5A5_A5A5; wr_tag = 4'hF;
    @(negedge clk);
    for (int n = 24; n < 28; n++) begin
      read_entry(n, got, v);
      check("R7 no write", got, pat(n, 1));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule